// File: doc/BRIEF.md
# Three-Slot Predicated Pipeline Core

This block is a small in-order processor core. On every clock it fetches one 45-bit line from instruction memory, and each line holds three 15-bit instructions that travel down the pipeline together. The four stages are line fetch into an instruction register, operand read, execute, and commit. Every instruction names a predicate bit. The instruction changes state only when that bit is 1.

The core has no interlocks of any kind: no hazard detection, no forwarding and no stalls. Software has to respect a fixed timing contract. A register result can be read by a line at least three lines later. A predicate result can be used by a line at least two lines later. A taken jump takes effect on the fourth line after it, and the three lines already in flight behind it still execute. The only outside connections are the instruction memory read port, an 8-bit switch input and an 8-bit display register. The instruction memory is read combinationally at `imem_addr`.

Top module: `vliw3_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` and `disp_out` are 0. All eight 8-bit registers and all predicate bits are 0.
- R2: Slot 0 of a line occupies bits [44:30], slot 1 occupies [29:15] and slot 2 occupies [14:0]. Within an instruction, the opcode is at [14:11], the predicate select at [10:8], the first register field (ra) at [7:5], the second (rb) at [4:2], and the 8-bit immediate at [7:0]. With no taken jump, `imem_addr` rises by one each cycle, wrapping from 255 to 0.
- R3: The register-writing operations are as follows. Opcode 1 copies ra into rb. Opcode 2 sets rb to ra+rb, modulo 256. Opcode 3 sets rb to ra AND rb. Opcode 8 sets rb to NOT ra. Opcode 11 sets rb to ra shifted right logically by one. Opcode 12 sets rb to ra shifted left by one. Opcode 13 sets rb to ra shifted right arithmetically by one. Opcode 4 loads the immediate into register 0.
- R4: A line reads register values during its second cycle in the core and writes during its fourth. A line three or more lines after a writer sees the new value. A line two after the writer sees the old value.
- R5: Opcode 15 sets predicate bit rb to (ra == 0). A line two or more lines later sees the new bit. Predicate select 0 always reads as 1, and writing it has no effect.
- R6: A slot whose predicate bit is 0 changes no register, no predicate, no display value and no program counter.
- R7: When several slots of one line write the same register, the highest-numbered slot's value remains.
- R8: Opcode 5 jumps to the line given by the immediate. Lines L+1 to L+3 after a taken jump at line L still execute. `imem_addr` shows the target after the fourth clock edge from L's fetch. When several slots take a jump, the lowest-numbered slot wins.
- R9: Opcode 9 copies ra to `disp_out` at commit. Opcode 10 loads `sw_in`, sampled in the execute stage, into rb.
- R10: Opcodes 0, 6, 7 and 14 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 8 | Line address into instruction memory (the program counter) |
| imem_line | input | 45 | Instruction line read at `imem_addr` |
| sw_in | input | 8 | Switch bank input |
| disp_out | output | 8 | Display value register |

## Verification
On every cycle, the checker enforces the following:
- reset clears the program counter and display;
- the address steps by one when no jump commits;
- a committed jump lands on its target;
- the display holds when no enabled output commits;
- slot 2 wins over slot 1 on a shared target.

Only the bench's programs can show the rest:
- operation results;
- the exact spacing at which a register or predicate value becomes visible or stays stale;
- execution of in-flight lines behind a jump;
- jump slot priority;
- switch capture;
- the inertness of unused opcodes and false predicates.

// File: rtl/vliw3_core.sv
module vliw3_core (
  input  logic        clk,
  input  logic        rst_n,
  output logic [7:0]  imem_addr,
  input  logic [44:0] imem_line,
  input  logic [7:0]  sw_in,
  output logic [7:0]  disp_out
);
  localparam int NSLOT = 3;
  localparam int IW    = 15;
  localparam int LW    = NSLOT * IW;
  localparam int NREG  = 8;

  localparam logic [3:0] OP_MOV = 4'd1, OP_ADD = 4'd2, OP_AND = 4'd3, OP_LDI = 4'd4,
                         OP_JMP = 4'd5, OP_INV = 4'd8, OP_OUT = 4'd9, OP_IN  = 4'd10,
                         OP_SHR = 4'd11, OP_SHL = 4'd12, OP_SRA = 4'd13, OP_ISZ = 4'd15;

  logic [7:0]    pc, disp;
  logic [LW-1:0] ir;
  logic [IW-1:0] ir_slot [NSLOT];
  logic [IW-1:0] of_ins  [NSLOT];
  logic [7:0]    of_a    [NSLOT];
  logic [7:0]    of_b    [NSLOT];
  logic [7:0]    x_val   [NSLOT];
  logic [2:0]    x_tgt   [NSLOT];
  logic          x_en    [NSLOT];
  logic [3:0]    ex_op   [NSLOT];
  logic          ex_en   [NSLOT];
  logic [2:0]    ex_tgt  [NSLOT];
  logic [7:0]    ex_val  [NSLOT];
  logic [7:0]    regs    [NREG];
  logic [7:0]    pred;
  logic          jmp_take;
  logic [7:0]    jmp_tgt;

  function automatic logic [7:0] alu(input logic [3:0] op, input logic [7:0] a,
                                     input logic [7:0] b, input logic [7:0] imm,
                                     input logic [7:0] sw);
    logic [7:0] r;
    case (op)
      OP_MOV, OP_OUT: r = a;
      OP_ADD:         r = a + b;
      OP_AND:         r = a & b;
      OP_LDI, OP_JMP: r = imm;
      OP_INV:         r = ~a;
      OP_IN:          r = sw;
      OP_SHR:         r = {1'b0, a[7:1]};
      OP_SHL:         r = {a[6:0], 1'b0};
      OP_SRA:         r = {a[7], a[7:1]};
      OP_ISZ:         r = {7'd0, a == 8'd0};
      default:        r = 8'd0;
    endcase
    return r;
  endfunction

  function automatic logic writes_reg(input logic [3:0] op);
    return op inside {OP_MOV, OP_ADD, OP_AND, OP_LDI, OP_INV, OP_IN, OP_SHR, OP_SHL, OP_SRA};
  endfunction

  assign imem_addr = pc;
  assign disp_out  = disp;

  // fetch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      ir <= '0;
    end else begin
      ir <= imem_line;
      pc <= jmp_take ? jmp_tgt : pc + 8'd1;
    end
  end

  always_comb
    for (int s = 0; s < NSLOT; s++) ir_slot[s] = ir[LW-1-IW*s -: IW];

  // operand read: both register fields, always
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        of_ins[s] <= '0;
        of_a[s]   <= '0;
        of_b[s]   <= '0;
      end
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        of_ins[s] <= ir_slot[s];
        of_a[s]   <= regs[ir_slot[s][7:5]];
        of_b[s]   <= regs[ir_slot[s][4:2]];
      end
    end
  end

  // execute: result, target and predicate per slot
  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      x_val[s] = alu(of_ins[s][14:11], of_a[s], of_b[s], of_ins[s][7:0], sw_in);
      x_tgt[s] = (of_ins[s][14:11] == OP_LDI) ? 3'd0 : of_ins[s][4:2];
      x_en[s]  = (of_ins[s][10:8] == 3'd0) || pred[of_ins[s][10:8]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        ex_op[s]  <= '0;
        ex_en[s]  <= 1'b0;
        ex_tgt[s] <= '0;
        ex_val[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        ex_op[s]  <= of_ins[s][14:11];
        ex_en[s]  <= x_en[s];
        ex_tgt[s] <= x_tgt[s];
        ex_val[s] <= x_val[s];
      end
    end
  end

  // commit: later slots overwrite earlier ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      pred <= '0;
      disp <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (ex_en[s]) begin
          if (writes_reg(ex_op[s])) regs[ex_tgt[s]] <= ex_val[s];
          if (ex_op[s] == OP_OUT) disp <= ex_val[s];
          if (ex_op[s] == OP_ISZ && ex_tgt[s] != 3'd0) pred[ex_tgt[s]] <= ex_val[s][0];
        end
      end
    end
  end

  // jump: lowest slot wins
  always_comb begin
    jmp_take = 1'b0;
    jmp_tgt  = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (ex_en[s] && ex_op[s] == OP_JMP) begin
        jmp_take = 1'b1;
        jmp_tgt  = ex_val[s];
      end
    end
  end
endmodule

// File: rtl/vliw3_core_chk.sv
module vliw3_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] pc,
  input logic [7:0] disp,
  input logic [3:0] ex_op  [3],
  input logic       ex_en  [3],
  input logic [2:0] ex_tgt [3],
  input logic [7:0] ex_val [3],
  input logic [7:0] regs   [8],
  input logic       jmp_take,
  input logic [7:0] jmp_tgt
);
  function automatic logic reg_op(input logic [3:0] op);
    return op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd8, 4'd10, 4'd11, 4'd12, 4'd13};
  endfunction

  logic       out_fire, dup12;
  logic [2:0] last_t;
  logic [7:0] last_v, last_jt;

  always_comb begin
    out_fire = 1'b0;
    for (int s = 0; s < 3; s++)
      if (ex_en[s] && ex_op[s] == 4'd9) out_fire = 1'b1;
  end

  assign dup12 = ex_en[1] && ex_en[2] && reg_op(ex_op[1]) && reg_op(ex_op[2]) &&
                 ex_tgt[1] == ex_tgt[2];

  always_ff @(posedge clk) begin
    last_t  <= ex_tgt[2];
    last_v  <= ex_val[2];
    last_jt <= jmp_tgt;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pc == 8'd0 && disp == 8'd0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_take |=> pc == $past(pc) + 8'd1);

  assert_jump_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_take |=> pc == last_jt);

  assert_disp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_fire |=> $stable(disp));

  assert_slot_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dup12 |=> regs[last_t] == last_v);
endmodule

bind vliw3_core vliw3_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .disp(disp),
  .ex_op(ex_op), .ex_en(ex_en), .ex_tgt(ex_tgt), .ex_val(ex_val),
  .regs(regs), .jmp_take(jmp_take), .jmp_tgt(jmp_tgt)
);

// File: tb/test_vliw3_core.sv
module test_vliw3_core;
  localparam logic [3:0] NOP = 0, MOV = 1, ADD = 2, ANDO = 3, LDI = 4, JMP = 5,
                         INV = 8, OUTO = 9, INO = 10, SHR = 11, SHL = 12, SRA = 13, ISZ = 15;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  imem_addr, sw = 8'd0, disp;
  logic [44:0] imem_line;
  logic [44:0] prog [256];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign imem_line = prog[imem_addr];

  vliw3_core i_vliw3_core (.clk(clk), .rst_n(rst_n), .imem_addr(imem_addr),
                           .imem_line(imem_line), .sw_in(sw), .disp_out(disp));

  function automatic logic [14:0] rr(logic [3:0] op, logic [2:0] p, logic [2:0] a, logic [2:0] b);
    return {op, p, a, b, 2'b00};
  endfunction
  function automatic logic [14:0] im(logic [3:0] op, logic [2:0] p, logic [7:0] v);
    return {op, p, v};
  endfunction
  function automatic logic [7:0] ref_alu(logic [3:0] op, logic [7:0] a, logic [7:0] b);
    case (op)
      MOV: return a;
      ADD: return a + b;
      ANDO: return a & b;
      INV: return ~a;
      SHR: return a >> 1;
      SHL: return a << 1;
      default: return {a[7], a[7:1]};
    endcase
  endfunction

  task automatic put(int ln, int slot, logic [14:0] w);
    prog[ln][44-15*slot -: 15] = w;
  endtask
  task automatic wipe();
    for (int i = 0; i < 256; i++) prog[i] = '0;
  endtask
  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask
  task automatic start();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 addr", imem_addr, 8'd0);
    chk("R1 disp", disp, 8'd0);
    @(negedge clk) rst_n = 1'b1;
  endtask
  task automatic step(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [3:0] ops [7];
    void'($urandom(32'd4242));
    ops = '{MOV, ADD, ANDO, INV, SHR, SHL, SRA};

    // R3 R2: random operations in random slots
    for (int it = 0; it < 40; it++) begin
      logic [7:0] a, b;
      logic [3:0] op;
      int s9, s12;
      a = 8'($urandom); b = 8'($urandom);
      op = ops[$urandom % 7];
      s9 = $urandom % 3; s12 = $urandom % 3;
      wipe();
      put(0, 0, im(LDI, 0, a));
      put(3, 0, rr(MOV, 0, 0, 1));
      put(3, 1, im(LDI, 0, b));
      put(6, 0, rr(MOV, 0, 0, 2));
      put(9, s9, rr(op, 0, 1, 2));
      put(12, s12, rr(OUTO, 0, 2, 0));
      start();
      step(16);
      chk($sformatf("R3 op %0d slot %0d", op, s9), disp, ref_alu(op, a, b));
    end

    // R4: spacing 2 reads stale, spacing 3 reads new
    for (int it = 0; it < 4; it++) begin
      logic [7:0] a, b;
      a = 8'($urandom) | 8'h01; b = a ^ 8'h80;
      wipe();
      put(0, 0, im(LDI, 0, a));
      put(5, 1, im(LDI, 0, b));
      put(7, 2, rr(MOV, 0, 0, 2));
      put(8, 0, rr(MOV, 0, 0, 3));
      put(10, 0, rr(OUTO, 0, 2, 0));
      put(11, 1, rr(OUTO, 0, 3, 0));
      start();
      step(14);
      chk("R4 stale at spacing 2", disp, a);
      step(1);
      chk("R4 fresh at spacing 3", disp, b);
    end

    // R5 R6: predicate write, predicate 0 stays 1, false predicate inert
    for (int it = 0; it < 6; it++) begin
      logic [7:0] a;
      a = (it % 2 == 0) ? 8'd0 : (8'($urandom) | 8'h04);
      wipe();
      put(0, 0, im(LDI, 0, a));
      put(3, 1, rr(ISZ, 0, 0, 1));
      put(3, 2, rr(ISZ, 0, 0, 0));
      put(5, 0, im(LDI, 1, 8'h55));
      put(5, 1, rr(MOV, 2, 0, 4));
      put(8, 0, rr(OUTO, 0, 0, 0));
      put(9, 2, rr(OUTO, 0, 4, 0));
      start();
      step(12);
      chk("R5 predicate result", disp, (a == 0) ? 8'h55 : a);
      step(1);
      chk("R6 false predicate left r4", disp, 8'h00);
    end

    // R8: jump priority, in-flight lines, target address
    wipe();
    put(0, 0, im(JMP, 2, 8'd40));
    put(0, 1, im(JMP, 0, 8'd8));
    put(0, 2, im(JMP, 0, 8'd12));
    put(1, 0, im(LDI, 0, 8'h11));
    put(3, 2, im(LDI, 0, 8'h33));
    put(4, 0, im(LDI, 0, 8'h44));
    put(10, 0, rr(OUTO, 0, 0, 0));
    start();
    step(3);
    chk("R8 pc before jump", imem_addr, 8'd3);
    step(1);
    chk("R8 lowest taken jump target", imem_addr, 8'd8);
    step(1);
    chk("R8 step after target", imem_addr, 8'd9);
    step(5);
    chk("R8 in-flight line ran, skipped line did not", disp, 8'h33);

    // R7 R10 R6: same-target priority, unused opcodes, false output and jump
    wipe();
    put(0, 0, im(LDI, 0, 8'h10));
    put(0, 1, im(LDI, 0, 8'h20));
    put(0, 2, im(LDI, 0, 8'h30));
    put(1, 0, {4'd14, 3'd0, 8'h00});
    put(1, 1, {4'd6, 3'd0, 8'h00});
    put(1, 2, {4'd7, 3'd0, 8'h00});
    put(4, 0, rr(OUTO, 3, 5, 0));
    put(3, 1, rr(OUTO, 0, 0, 0));
    put(5, 0, im(JMP, 3, 8'd0));
    start();
    step(7);
    chk("R7 R10 highest slot kept, unused opcodes inert", disp, 8'h30);
    step(1);
    chk("R6 false output ignored", disp, 8'h30);
    step(1);
    chk("R6 false jump ignored", imem_addr, 8'd9);

    // R9: switch input to display
    for (int it = 0; it < 10; it++) begin
      logic [7:0] v;
      int so;
      v = 8'($urandom); so = $urandom % 3;
      wipe();
      sw = v;
      put(0, 2, rr(INO, 0, 0, 3));
      put(3, so, rr(OUTO, 0, 3, 0));
      start();
      step(7);
      chk("R9 switch to display", disp, v);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule